// File: doc/BRIEF.md
# Region Access Permission Checker

This block sits in front of a node's local register space and coherent read path and decides, for every incoming request, which reply the interface must return. It holds three per-region permission vectors: one for processor-initiated accesses to the local registers, one for interrupt writes that arrive from the IO side, and one that records which regions of the machine actually exist. A request names its source region, its kind (partial read, partial write or coherent read), whether it came from the IO side and whether its address falls in the node's alias window. One cycle after it is accepted, the block answers with a 3-bit reply code. Alongside the code it raises a flag saying that the event must not be logged in the error registers.

Software reads and writes the three vectors through a simple configuration port. A separate override port lets a requester grant itself access. A write to that port carrying the guard pattern sets the writer's own bit in the processor vector, and any other data is dropped. A hard reset opens every region. A soft reset only flushes the response stage, and all three vectors keep their contents through it.

Top module: `region_access_checker`

## Requirements
- R1: Each vector has one bit per region, and bit i governs requests whose source region is i. A hard reset (`rst_n` low at a clock edge) sets all three vectors to all ones.
- R2: A partial read (kind 0) from the processor side whose region bit is set in the processor vector returns REPLY (code 0). A partial write (kind 1) in the same case returns ACK (code 1).
- R3: If that processor-vector bit is clear, a partial read returns RERR (code 2) and a partial write returns WERR (code 3).
- R4: A partial access with `req_is_io` high is judged against the IO vector instead. It returns the same codes: 0 or 1 when allowed, 2 or 3 when denied.
- R5: The present vector affects only coherent reads (kind 2). A partial access is judged only by its protect vector, whatever the present bit for its region holds.
- R6: A coherent read to a region whose present bit is clear returns ERR (code 4) with `rsp_log_suppress` high. A coherent read to a present region returns PASS (code 5) with `rsp_log_suppress` low. Kind 3 always returns PASS.
- R7: A coherent read with `req_in_alias` high returns PASS, whatever the present bit holds.
- R8: An override write whose data equals the guard pattern (default 64'hA5A5_5A5A_C3C3_3C3C) sets bit `ovr_region` of the processor vector. An override write with any other data leaves every vector unchanged.
- R9: If a configuration write to the processor vector and a matching override write occur in the same cycle, the new vector is the written data ORed with the override bit.
- R10: A soft reset leaves all three vectors unchanged. While it is low, it holds `rsp_valid` low and `req_ready` low. `req_ready` is also low during a hard reset.
- R11: `rsp_valid` is high in the cycle after a request is accepted (`req_valid` and `req_ready` both high), and low after any cycle with no accepted request.
- R12: `cfg_rdata` shows the vector picked by `cfg_sel`: 0 selects the processor vector, 1 the IO vector, 2 the present vector, and 3 reads as zero. A configuration write with `cfg_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low; vectors kept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high |
| req_region | input | 6 | Source region of the request |
| req_kind | input | 2 | 0 partial read, 1 partial write, 2 coherent read, 3 other |
| req_is_io | input | 1 | Request is an IO-side interrupt write |
| req_in_alias | input | 1 | Address lies in the node's alias window |
| rsp_valid | output | 1 | Reply code valid |
| rsp_code | output | 3 | 0 REPLY, 1 ACK, 2 RERR, 3 WERR, 4 ERR, 5 PASS |
| rsp_log_suppress | output | 1 | Error registers must not be updated for this reply |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Vector select for read and write |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Selected vector |
| ovr_we | input | 1 | Override write strobe |
| ovr_wdata | input | 64 | Override write data, compared with the guard pattern |
| ovr_region | input | 6 | Region of the requester issuing the override |

## Verification
The assertions assume the request fields are meaningful only while `req_valid` is high. They also assume every change to a vector comes through the configuration or override strobes, or a hard reset. The bench drives every input at the falling edge and holds it for one full cycle. It never raises `req_valid` during either reset, so every accepted request falls in a cycle where both resets are high. It checks the response one cycle later, away from the edge where that response is registered.

// File: rtl/region_chk_pkg.sv
// Package: shared encodings for the region access checker.
// Assumes: nothing; pure type definitions.
package region_chk_pkg;

    typedef enum logic [2:0] {
        RSP_REPLY = 3'd0,
        RSP_ACK   = 3'd1,
        RSP_RERR  = 3'd2,
        RSP_WERR  = 3'd3,
        RSP_ERR   = 3'd4,
        RSP_PASS  = 3'd5
    } rsp_code_e;

    typedef enum logic [1:0] {
        KIND_PRD   = 2'd0,
        KIND_PWR   = 2'd1,
        KIND_CRD   = 2'd2,
        KIND_OTHER = 2'd3
    } req_kind_e;

    localparam int unsigned NUM_VEC  = 3;
    localparam int unsigned VEC_CPU  = 0;
    localparam int unsigned VEC_IO   = 1;
    localparam int unsigned VEC_PRES = 2;

endpackage

// File: rtl/region_vec_reg.sv
// Module: one per-region permission vector.
// Assumes: set_mask is applied after the write, so a set bit survives a same-cycle write.
//          The vector is cleared to all ones only by the hard reset.
module region_vec_reg #(
    parameter int unsigned NREG = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREG-1:0] wr_data,
    input  logic [NREG-1:0] set_mask,
    output logic [NREG-1:0] q
);

    logic [NREG-1:0] written;

    // Select the written value or keep the old one.
    always_comb begin
        written = wr_en ? wr_data : q;
    end

    // Hold the vector; a hard reset opens every region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= written | set_mask;
        end
    end

endmodule

// File: rtl/region_decide.sv
// Module: combinational reply decision for one request.
// Assumes: the vectors are stable during the cycle; kind 3 is a request
//          that this block passes through unchanged.
module region_decide
    import region_chk_pkg::*;
#(
    parameter int unsigned NREG   = 64,
    parameter int unsigned RIDX_W = 6
) (
    input  logic [RIDX_W-1:0] region,
    input  logic [1:0]        kind,
    input  logic              is_io,
    input  logic              in_alias,
    input  logic [NREG-1:0]   cpu_vec,
    input  logic [NREG-1:0]   io_vec,
    input  logic [NREG-1:0]   pres_vec,
    output rsp_code_e         code,
    output logic              log_suppress
);

    logic allowed;
    logic present;

    // Pick the protect bit that applies to the request's source side.
    always_comb begin
        allowed = is_io ? io_vec[region] : cpu_vec[region];
        present = pres_vec[region] | in_alias;
    end

    // Map kind and permission onto the reply code.
    always_comb begin
        log_suppress = 1'b0;
        unique case (req_kind_e'(kind))
            KIND_PRD: code = allowed ? RSP_REPLY : RSP_RERR;
            KIND_PWR: code = allowed ? RSP_ACK   : RSP_WERR;
            KIND_CRD: begin
                code         = present ? RSP_PASS : RSP_ERR;
                log_suppress = !present;
            end
            default:  code = RSP_PASS;
        endcase
    end

endmodule

// File: rtl/region_access_checker.sv
// Module: top of the region access permission checker.
// Assumes: the request fields matter only while req_valid is high;
//          rst_n is the hard reset, and soft_rst_n resets only the response stage.
module region_access_checker
    import region_chk_pkg::*;
#(
    parameter int unsigned     NREG        = 64,
    parameter logic [NREG-1:0] OVR_PATTERN = 64'hA5A5_5A5A_C3C3_3C3C,
    localparam int unsigned    RIDX_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RIDX_W-1:0] req_region,
    input  logic [1:0]        req_kind,
    input  logic              req_is_io,
    input  logic              req_in_alias,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic              rsp_log_suppress,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [NREG-1:0]   cfg_wdata,
    output logic [NREG-1:0]   cfg_rdata,
    input  logic              ovr_we,
    input  logic [NREG-1:0]   ovr_wdata,
    input  logic [RIDX_W-1:0] ovr_region
);

    logic [NREG-1:0] vec [NUM_VEC];
    logic [NREG-1:0] cpu_vec;
    logic [NREG-1:0] io_vec;
    logic [NREG-1:0] pres_vec;
    logic [NREG-1:0] ovr_mask;
    rsp_code_e       dec_code;
    logic            dec_sup;
    logic            fire;

    // Decode a guarded override into a one-hot set mask.
    always_comb begin
        ovr_mask = '0;
        if (ovr_we && (ovr_wdata == OVR_PATTERN)) begin
            ovr_mask[ovr_region] = 1'b1;
        end
    end

    // Build the three vectors; only the processor vector takes the override.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic [NREG-1:0] set_m;
        if (g == VEC_CPU) begin : g_ovr
            assign set_m = ovr_mask;
        end else begin : g_plain
            assign set_m = '0;
        end
        region_vec_reg #(.NREG(NREG)) u_vec (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_sel == 2'(g))),
            .wr_data  (cfg_wdata),
            .set_mask (set_m),
            .q        (vec[g])
        );
    end

    assign cpu_vec  = vec[VEC_CPU];
    assign io_vec   = vec[VEC_IO];
    assign pres_vec = vec[VEC_PRES];

    // Return the selected vector; select 3 reads as zero.
    always_comb begin
        cfg_rdata = (cfg_sel < 2'(NUM_VEC)) ? vec[cfg_sel] : '0;
    end

    region_decide #(.NREG(NREG), .RIDX_W(RIDX_W)) u_decide (
        .region       (req_region),
        .kind         (req_kind),
        .is_io        (req_is_io),
        .in_alias     (req_in_alias),
        .cpu_vec      (cpu_vec),
        .io_vec       (io_vec),
        .pres_vec     (pres_vec),
        .code         (dec_code),
        .log_suppress (dec_sup)
    );

    // Accept requests only when neither reset is active.
    always_comb begin
        req_ready = rst_n && soft_rst_n;
        fire      = req_valid && req_ready;
    end

    // Register the reply one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_code         <= RSP_PASS;
            rsp_log_suppress <= 1'b0;
        end else begin
            rsp_valid        <= fire;
            rsp_code         <= fire ? dec_code : rsp_code;
            rsp_log_suppress <= fire && dec_sup;
        end
    end

endmodule

// File: rtl/region_chk_sva.sv
// Module: property checker for the region access checker, bound to the top.
// Assumes: all vector changes come from the configuration or override strobes, or a hard reset.
module region_chk_sva #(
    parameter int unsigned     NREG        = 64,
    parameter logic [NREG-1:0] OVR_PATTERN = 64'hA5A5_5A5A_C3C3_3C3C
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_kind,
    input logic            req_in_alias,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic            rsp_log_suppress,
    input logic            cfg_we,
    input logic [1:0]      cfg_sel,
    input logic            ovr_we,
    input logic [NREG-1:0] ovr_wdata,
    input logic [NREG-1:0] cpu_vec,
    input logic [NREG-1:0] io_vec,
    input logic [NREG-1:0] pres_vec
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n || !soft_rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R11

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !soft_rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R11

    AST_READY_IN_RESET: assert property (@(posedge clk)
        !soft_rst_n |-> !req_ready); // R10

    AST_SUPPRESS_ONLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_log_suppress) |-> (rsp_code == 3'd4)); // R6

    AST_PARTIAL_IGNORES_PRES: assert property (@(posedge clk) disable iff (!rst_n || !soft_rst_n)
        (req_valid && req_ready && req_kind == 2'd0) |=> (rsp_code == 3'd0 || rsp_code == 3'd2)); // R5

    AST_ALIAS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n || !soft_rst_n)
        (req_valid && req_ready && req_kind == 2'd2 && req_in_alias) |=> (rsp_code == 3'd5)); // R7

    AST_BAD_PATTERN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_we && ovr_wdata != OVR_PATTERN && !(cfg_we && cfg_sel == 2'd0)) |=> $stable(cpu_vec)); // R8

    AST_IO_VEC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == 2'd1) |=> $stable(io_vec)); // R10

    AST_PRES_VEC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == 2'd2) |=> $stable(pres_vec)); // R10

endmodule

bind region_access_checker region_chk_sva #(.NREG(NREG), .OVR_PATTERN(OVR_PATTERN)) u_chk_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .soft_rst_n       (soft_rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_kind         (req_kind),
    .req_in_alias     (req_in_alias),
    .rsp_valid        (rsp_valid),
    .rsp_code         (rsp_code),
    .rsp_log_suppress (rsp_log_suppress),
    .cfg_we           (cfg_we),
    .cfg_sel          (cfg_sel),
    .ovr_we           (ovr_we),
    .ovr_wdata        (ovr_wdata),
    .cpu_vec          (cpu_vec),
    .io_vec           (io_vec),
    .pres_vec         (pres_vec)
);

// File: tb/test_region_access_checker.sv
// Bench: table walk of request cases, then directed reset, override and soft reset tests.
module test_region_access_checker;

    localparam logic [63:0] PAT = 64'hA5A5_5A5A_C3C3_3C3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_region = '0;
    logic [1:0]  req_kind = '0;
    logic        req_is_io = 1'b0;
    logic        req_in_alias = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic        rsp_log_suppress;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        ovr_we = 1'b0;
    logic [63:0] ovr_wdata = '0;
    logic [5:0]  ovr_region = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    region_access_checker i_region_access_checker (.*);

    // Fields per entry: {region[5:0], kind[1:0], is_io, alias, code[2:0]}.
    localparam int NV = 13;
    localparam logic [12:0] VEC [NV] = '{
        {6'd5,  2'd0, 1'b0, 1'b0, 3'd0},  // R2 allowed read
        {6'd5,  2'd1, 1'b0, 1'b0, 3'd1},  // R2 allowed write
        {6'd6,  2'd0, 1'b0, 1'b0, 3'd2},  // R3 denied read
        {6'd6,  2'd1, 1'b0, 1'b0, 3'd3},  // R3 denied write
        {6'd7,  2'd0, 1'b1, 1'b0, 3'd0},  // R4 io allowed read
        {6'd7,  2'd1, 1'b1, 1'b0, 3'd1},  // R4 io allowed write
        {6'd8,  2'd0, 1'b1, 1'b0, 3'd2},  // R4 io denied read
        {6'd8,  2'd1, 1'b1, 1'b0, 3'd3},  // R4 io denied write
        {6'd5,  2'd0, 1'b1, 1'b0, 3'd2},  // R4 io vector, not cpu
        {6'd9,  2'd2, 1'b0, 1'b0, 3'd5},  // R6 present
        {6'd10, 2'd2, 1'b0, 1'b0, 3'd4},  // R6 absent
        {6'd10, 2'd2, 1'b0, 1'b1, 3'd5},  // R7 alias bypass
        {6'd63, 2'd3, 1'b0, 1'b0, 3'd5}   // R6 kind 3 passes
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [63:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic ovr_write(input logic [5:0] r, input logic [63:0] d);
        @(negedge clk);
        ovr_we = 1'b1; ovr_region = r; ovr_wdata = d;
        @(negedge clk);
        ovr_we = 1'b0;
    endtask

    // Send one request; outputs are sampled at the next falling edge.
    task automatic send(input logic [5:0] r, input logic [1:0] k, input logic io, input logic al);
        @(negedge clk);
        req_valid = 1'b1; req_region = r; req_kind = k; req_is_io = io; req_in_alias = al;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        chk("R10 ready low in hard reset", 64'(req_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R12 reset state
        chk("R11 no response after reset", 64'(rsp_valid), 64'd0);
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        for (int s = 0; s < 3; s++) begin
            cfg_read(2'(s), d);
            chk("R1 vector all ones after hard reset", d, '1);
        end
        cfg_read(2'd3, d);
        chk("R12 select 3 reads zero", d, 64'd0);

        cfg_write(2'd0, 64'h20);
        cfg_write(2'd1, 64'h80);
        cfg_write(2'd2, 64'h200);
        cfg_write(2'd3, 64'hFFFF);
        cfg_read(2'd0, d); chk("R12 cpu vector readback", d, 64'h20);
        cfg_read(2'd1, d); chk("R12 io vector readback", d, 64'h80);
        cfg_read(2'd2, d); chk("R12 present vector readback, sel 3 write ignored", d, 64'h200);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][12:7], VEC[i][6:5], VEC[i][4], VEC[i][3]);
            chk("R11 response valid", 64'(rsp_valid), 64'd1);
            chk("R2-R7 table code", 64'(rsp_code), 64'(VEC[i][2:0]));
            chk("R6 suppress flag", 64'(rsp_log_suppress), 64'(VEC[i][2:0] == 3'd4));
        end
        @(negedge clk);
        chk("R11 idle cycle gives no response", 64'(rsp_valid), 64'd0);

        // R5: partial read to absent region 6 present bit clear, region 5 allowed.
        send(6'd5, 2'd0, 1'b0, 1'b0);
        chk("R5 partial to absent region allowed", 64'(rsp_code), 64'd0);

        // R8 override.
        cfg_write(2'd0, 64'h0);
        ovr_write(6'd12, PAT);
        cfg_read(2'd0, d); chk("R8 good pattern sets own bit", d, 64'h1000);
        ovr_write(6'd13, PAT ^ 64'h1);
        cfg_read(2'd0, d); chk("R8 bad pattern ignored", d, 64'h1000);
        send(6'd13, 2'd0, 1'b0, 1'b0);
        chk("R8 bad pattern leaves region denied", 64'(rsp_code), 64'd2);
        send(6'd12, 2'd1, 1'b0, 1'b0);
        chk("R8 override region granted", 64'(rsp_code), 64'd1);

        // R9 collision.
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 64'h1;
        ovr_we = 1'b1; ovr_region = 6'd3; ovr_wdata = PAT;
        @(negedge clk);
        cfg_we = 1'b0; ovr_we = 1'b0;
        cfg_read(2'd0, d); chk("R9 write then override ORed", d, 64'h9);

        // R10 soft reset.
        @(negedge clk);
        req_valid = 1'b1; req_region = 6'd0; req_kind = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        soft_rst_n = 1'b0;
        #1 chk("R10 ready low in soft reset", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R10 soft reset clears response", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        soft_rst_n = 1'b1;
        cfg_read(2'd0, d); chk("R10 cpu vector kept", d, 64'h9);
        cfg_read(2'd1, d); chk("R10 io vector kept", d, 64'h80);
        cfg_read(2'd2, d); chk("R10 present vector kept", d, 64'h200);

        // R1 hard reset restores all ones.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_read(2'd2, d); chk("R1 hard reset reopens regions", d, '1);
        send(6'd10, 2'd2, 1'b0, 1'b0);
        chk("R1 coherent read passes after hard reset", 64'(rsp_code), 64'd5);

        finish_run();
    end

endmodule